// File: doc/BRIEF.md
# Flash Write-Protection and Status Controller

This block keeps the status byte of a serial flash device and decides which write-type commands may run. A serial front-end decodes each instruction and presents it for one clock as a strobe, with its 8-bit opcode, the target byte address and, for a status write, the new status byte. The block answers one clock later with an accept or a reject pulse. It also times the self-timed operation that follows, with cycle counters, and shows it on a busy flag.

Protection works at the level of 64 KB sectors. The three block-protect bits cover an upper fraction of the array: one eighth, one quarter, one half, or all of it. A lock bit, combined with the active-low write-protect pin, freezes the status byte against writes. The write-enable latch must be set before any program, erase or status write, and it is cleared when that operation completes. For a fixed number of cycles after reset, every write-related command is ignored.

The state machine has three states. ST_INHIBIT is the power-up hold; it moves to ST_READY when the power-up count expires. ST_READY takes commands; it moves to ST_BUSY when a timed operation is accepted. ST_BUSY runs the operation and returns to ST_READY when its count expires.

Top module: `flash_wp_ctrl`

## Requirements
- R1: The status byte has BUSY in bit 0, the write-enable latch (WEL) in bit 1, block-protect BP[2:0] in bits 4..2 and the lock bit in bit 7. Bits 6..5 always read 0. After reset the byte is {INIT_SRP, 2'b00, INIT_BP, 1'b0, 1'b0}.
- R2: For T_PWRUP cycles after reset, opcodes 06h, 04h, 01h, 02h, D8h and C7h are ignored: no pulse and no change to the status byte.
- R3: Outside power-up and busy, opcode 06h sets WEL and 04h clears it. Each gives a cmd_accept pulse in the cycle after the strobe. cmd_accept and cmd_reject are never high together.
- R4: Status write (01h), page program (02h), sector erase (D8h) and chip erase (C7h) get a cmd_reject pulse, and do not start, while WEL is 0.
- R5: A status write is rejected when the lock bit is 1 and wp_n is 0. When the lock bit is 0, wp_n has no effect.
- R6: An accepted status write changes only bits 7 and 4..2, taken from cmd_data. The new values appear when the operation ends.
- R7: A program or sector erase whose sector (cmd_addr[18:16]) is protected is rejected. The protected sectors by BP code are: 000 none, 001 sector 7, 010 sectors 6..7, 011 sectors 4..7, 1xx all.
- R8: Chip erase is rejected whenever BP is not 000.
- R9: An accepted timed operation holds busy (and status bit 0) at 1 for exactly T_WRSR, T_PROG, T_SERASE or T_CERASE cycles, starting in the cycle after the strobe. WEL clears in the same cycle that busy falls.
- R10: While busy, every command is ignored: no pulse, and WEL and BP are unchanged.
- R11: Opcodes other than the six above are ignored at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe from the serial front-end |
| cmd_op | input | 8 | Instruction opcode |
| cmd_addr | input | ADDR_W | Byte address for program or sector erase |
| cmd_data | input | 8 | New status byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Current status byte |
| busy | output | 1 | A self-timed operation is running |
| cmd_accept | output | 1 | Pulse: the previous strobe's command was carried out or started |
| cmd_reject | output | 1 | Pulse: the previous strobe's write command was refused |

## Verification
Every BP code is written into the status byte and then probed with program and erase commands at the first and last byte of each sector. This separates a sector-index decode from an off-by-one boundary and from a wrong fraction per code. Directed sequences try the lock bit against both levels of wp_n, commands sent during power-up and during busy, and a status write of FFh that must leave the read-only bits alone. A seeded random mix of all opcodes, addresses, data bytes and wp_n levels then runs against a bench model of WEL, BP and the lock bit. In that mix, each reject reason and each busy length is checked against the model.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    typedef enum logic [1:0] {
        ST_INHIBIT,
        ST_READY,
        ST_BUSY
    } fwp_state_e;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SERASE = 8'hD8;
    localparam logic [7:0] OP_CERASE = 8'hC7;

    function automatic int unsigned fwp_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fwp_prot_decode.sv
// Maps the block-protect code onto an upper range of sectors.
// SECT_BITS must be at least 3, so that one eighth is a whole sector.
module fwp_prot_decode #(
    parameter int SECT_BITS = 3
) (
    input  logic [2:0]           bp,
    input  logic [SECT_BITS-1:0] sector,
    output logic                 sector_prot,
    output logic                 any_prot
);
    localparam int NSECT = 1 << SECT_BITS;

    int span;

    always_comb begin
        if (bp[2])
            span = NSECT;
        else if (bp[1:0] == 2'b00)
            span = 0;
        else
            span = NSECT >> (4 - int'(bp[1:0]));
    end

    assign any_prot    = (span != 0);
    assign sector_prot = any_prot && (int'(sector) >= (NSECT - span));

endmodule

// File: rtl/fwp_timer.sv
// Down counter: preset at reset, reloadable, stops at zero.
module fwp_timer #(
    parameter int          CNT_W   = 32,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= CNT_W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import fwp_pkg::*;
#(
    parameter int          ADDR_W    = 19,
    parameter int          SECT_BITS = 3,
    parameter int unsigned T_PWRUP   = 1_000_000,
    parameter int unsigned T_WRSR    = 1_000_000,
    parameter int unsigned T_PROG    = 200_000,
    parameter int unsigned T_SERASE  = 70_000_000,
    parameter int unsigned T_CERASE  = 300_000_000,
    parameter logic [2:0]  INIT_BP   = 3'b000,
    parameter logic        INIT_SRP  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    output logic [7:0]        status,
    output logic              busy,
    output logic              cmd_accept,
    output logic              cmd_reject
);
    localparam int unsigned T_MAX = fwp_max(fwp_max(T_PWRUP, T_WRSR),
                                    fwp_max(fwp_max(T_PROG, T_SERASE), T_CERASE));
    localparam int CNT_W = $clog2(T_MAX) + 1;
    localparam logic [CNT_W-1:0] D_WRSR   = CNT_W'(T_WRSR - 1);
    localparam logic [CNT_W-1:0] D_PROG   = CNT_W'(T_PROG - 1);
    localparam logic [CNT_W-1:0] D_SERASE = CNT_W'(T_SERASE - 1);
    localparam logic [CNT_W-1:0] D_CERASE = CNT_W'(T_CERASE - 1);

    fwp_state_e state, state_nx;

    logic       wel, srp, pend_wrsr, pend_srp;
    logic [2:0] bp, pend_bp;
    logic       sector_prot, any_prot, expired;
    logic       go_acc, go_rej, go_timed;
    logic [CNT_W-1:0] dur;

    logic unused_bits;
    assign unused_bits = ^{cmd_data[6:5], cmd_data[1:0], cmd_addr[ADDR_W-SECT_BITS-1:0]};

    fwp_prot_decode #(.SECT_BITS(SECT_BITS)) u_prot (
        .bp          (bp),
        .sector      (cmd_addr[ADDR_W-1 -: SECT_BITS]),
        .sector_prot (sector_prot),
        .any_prot    (any_prot)
    );

    fwp_timer #(.CNT_W(CNT_W), .RST_VAL(T_PWRUP - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go_timed),
        .load_val (dur),
        .expired  (expired)
    );

    // Command judgement, only meaningful in ST_READY
    always_comb begin
        go_acc   = 1'b0;
        go_rej   = 1'b0;
        go_timed = 1'b0;
        dur      = D_PROG;
        if (state == ST_READY && cmd_valid) begin
            unique case (cmd_op)
                OP_WREN, OP_WRDI: go_acc = 1'b1;
                OP_WRSR: begin
                    go_timed = wel && !(srp && !wp_n);
                    dur      = D_WRSR;
                end
                OP_PROG: begin
                    go_timed = wel && !sector_prot;
                    dur      = D_PROG;
                end
                OP_SERASE: begin
                    go_timed = wel && !sector_prot;
                    dur      = D_SERASE;
                end
                OP_CERASE: begin
                    go_timed = wel && !any_prot;
                    dur      = D_CERASE;
                end
                default: ;
            endcase
            if (cmd_op == OP_WRSR || cmd_op == OP_PROG ||
                cmd_op == OP_SERASE || cmd_op == OP_CERASE) begin
                go_acc = go_timed;
                go_rej = !go_timed;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INHIBIT: if (expired)  state_nx = ST_READY;
            ST_READY:   if (go_timed) state_nx = ST_BUSY;
            ST_BUSY:    if (expired)  state_nx = ST_READY;
            default:    state_nx = ST_INHIBIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_INHIBIT;
        else
            state <= state_nx;
    end

    // Output and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel        <= 1'b0;
            bp         <= INIT_BP;
            srp        <= INIT_SRP;
            pend_wrsr  <= 1'b0;
            pend_bp    <= 3'b000;
            pend_srp   <= 1'b0;
            cmd_accept <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            cmd_accept <= go_acc;
            cmd_reject <= go_rej;
            if (state == ST_READY && cmd_valid) begin
                if (cmd_op == OP_WREN) wel <= 1'b1;
                if (cmd_op == OP_WRDI) wel <= 1'b0;
            end
            if (go_timed) begin
                pend_wrsr <= (cmd_op == OP_WRSR);
                pend_bp   <= cmd_data[4:2];
                pend_srp  <= cmd_data[7];
            end
            if (state == ST_BUSY && expired) begin
                wel <= 1'b0;
                if (pend_wrsr) begin
                    bp  <= pend_bp;
                    srp <= pend_srp;
                end
            end
        end
    end

    assign busy   = (state == ST_BUSY);
    assign status = {srp, 2'b00, bp, wel, busy};

endmodule

// File: rtl/fwp_checker.sv
module fwp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_op,
    input logic       wp_n,
    input logic [7:0] status,
    input logic       busy,
    input logic       cmd_accept,
    input logic       cmd_reject
);
    logic wr_op;
    assign wr_op = (cmd_op == 8'h01) || (cmd_op == 8'h02) ||
                   (cmd_op == 8'hD8) || (cmd_op == 8'hC7);

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:5] == 2'b00 && status[0] == busy);

    a_r3_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> !cmd_reject);

    a_r4_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && wr_op && !status[1]) |=> !cmd_accept);

    a_r5_srp_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 8'h01 && status[7] && !wp_n) |=> !cmd_accept);

    a_r8_chip_erase_prot: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 8'hC7 && status[4:2] != 3'b000) |=> !cmd_accept);

    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && $past(cmd_valid && wr_op)) |-> busy);

    a_r9_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !status[1]);

    a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!cmd_accept && !cmd_reject));

endmodule

bind flash_wp_ctrl fwp_checker u_chk (.*);

// File: tb/flash_wp_ctrl_tb.sv
module flash_wp_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int T_PWRUP  = 20;
    localparam int T_WRSR   = 6;
    localparam int T_PROG   = 4;
    localparam int T_SERASE = 9;
    localparam int T_CERASE = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [18:0] cmd_addr = '0;
    logic [7:0]  cmd_data = 8'h00;
    logic        wp_n = 1'b1;
    logic [7:0]  status;
    logic        busy, cmd_accept, cmd_reject;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic       m_wel = 1'b0, m_srp = 1'b0, m_inhibit = 1'b1;
    logic [2:0] m_bp = 3'b010;

    flash_wp_ctrl #(
        .ADDR_W(19), .SECT_BITS(3), .T_PWRUP(T_PWRUP), .T_WRSR(T_WRSR),
        .T_PROG(T_PROG), .T_SERASE(T_SERASE), .T_CERASE(T_CERASE),
        .INIT_BP(3'b010), .INIT_SRP(1'b0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
        .status(status), .busy(busy), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic prot(input logic [2:0] b, input logic [2:0] sec);
        case (b)
            3'b000: return 1'b0;
            3'b001: return sec == 3'd7;
            3'b010: return sec == 3'd6 || sec == 3'd7;
            3'b011: return sec[2];
            default: return 1'b1;
        endcase
    endfunction

    // 0 ignored, 1 accepted, 2 rejected
    function automatic int exp_res(input logic [7:0] op, input logic [18:0] a, input logic wp);
        if (m_inhibit) return 0;
        case (op)
            8'h06, 8'h04: return 1;
            8'h01: return (m_wel && !(m_srp && !wp)) ? 1 : 2;
            8'h02, 8'hD8: return (m_wel && !prot(m_bp, a[18:16])) ? 1 : 2;
            8'hC7: return (m_wel && m_bp == 3'b000) ? 1 : 2;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_dur(input logic [7:0] op);
        case (op)
            8'h01: return T_WRSR;
            8'h02: return T_PROG;
            8'hD8: return T_SERASE;
            default: return T_CERASE;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_srp, 2'b00, m_bp, m_wel, 1'b0};
    endfunction

    task automatic do_cmd(input logic [7:0] op, input logic [18:0] a, input logic [7:0] d,
                          input logic wp, input string tag);
        int res;
        int n;
        res = exp_res(op, a, wp);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; wp_n = wp;
        @(negedge clk);
        cmd_valid = 1'b0;
        check({tag, " pulses"}, {30'd0, cmd_accept, cmd_reject},
              res == 1 ? 32'd2 : (res == 2 ? 32'd1 : 32'd0));
        if (res == 1) begin
            if (op == 8'h06) m_wel = 1'b1;
            else if (op == 8'h04) m_wel = 1'b0;
            else begin
                n = 0;
                while (busy === 1'b1 && n < 1000) begin
                    n++;
                    @(negedge clk);
                end
                check({tag, " R9 busy length"}, n, exp_dur(op));
                m_wel = 1'b0;
                if (op == 8'h01) begin
                    m_bp  = d[4:2];
                    m_srp = d[7];
                end
            end
        end
        check({tag, " status"}, {24'd0, status}, {24'd0, exp_status()});
    endtask

    logic [7:0] ops [7] = '{8'h06, 8'h04, 8'h01, 8'h02, 8'hD8, 8'hC7, 8'h03};

    initial begin
        int r;
        r = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset value with preset BP=010
        check("R1 reset status", {24'd0, status}, 32'h08);
        check("R1 reset busy", {31'd0, busy}, 0);
        // R2 power-up inhibit
        do_cmd(8'h06, '0, 8'h00, 1'b1, "R2 wren in inhibit");
        do_cmd(8'h01, '0, 8'hFF, 1'b1, "R2 wrsr in inhibit");
        repeat (T_PWRUP + 2) @(negedge clk);
        m_inhibit = 1'b0;
        // R3 enable/disable
        do_cmd(8'h06, '0, 8'h00, 1'b1, "R3 wren");
        do_cmd(8'h04, '0, 8'h00, 1'b1, "R3 wrdi");
        // R4 without WEL
        do_cmd(8'h02, 19'h00010, 8'h00, 1'b1, "R4 prog no wel");
        do_cmd(8'hC7, '0, 8'h00, 1'b1, "R4 chip erase no wel");
        // R6 only writable bits change
        do_cmd(8'h06, '0, 8'h00, 1'b1, "R6 wren");
        do_cmd(8'h01, '0, 8'hFF, 1'b1, "R6 wrsr FF");
        // R5 lock with wp_n
        do_cmd(8'h06, '0, 8'h00, 1'b0, "R5 wren");
        do_cmd(8'h01, '0, 8'h00, 1'b0, "R5 locked wrsr");
        do_cmd(8'h01, '0, 8'h00, 1'b1, "R5 unlocked wrsr");
        do_cmd(8'h06, '0, 8'h00, 1'b0, "R5 wren2");
        do_cmd(8'h01, '0, 8'h04, 1'b0, "R5 srp0 wp ignored");
        // R11 unknown opcode
        do_cmd(8'h06, '0, 8'h00, 1'b1, "R11 wren");
        do_cmd(8'h9F, '0, 8'h00, 1'b1, "R11 unknown");
        do_cmd(8'h03, '0, 8'h00, 1'b1, "R11 read");
        // R7/R8 sweep of every BP code against sector boundaries
        for (int b = 0; b < 8; b++) begin
            do_cmd(8'h06, '0, 8'h00, 1'b1, "R7 wren");
            do_cmd(8'h01, '0, {3'b000, 3'(b), 2'b00}, 1'b1, "R7 set bp");
            for (int s = 0; s < 8; s++) begin
                for (int e = 0; e < 2; e++) begin
                    do_cmd(8'h06, '0, 8'h00, 1'b1, "R7 wren");
                    do_cmd(8'h02, {3'(s), (e == 1) ? 16'hFFFF : 16'h0000}, 8'h00, 1'b1, "R7 prog boundary");
                end
                do_cmd(8'h06, '0, 8'h00, 1'b1, "R7 wren");
                do_cmd(8'hD8, {3'(s), 16'h0000}, 8'h00, 1'b1, "R7 sector erase");
            end
            do_cmd(8'h06, '0, 8'h00, 1'b1, "R8 wren");
            do_cmd(8'hC7, '0, 8'h00, 1'b1, "R8 chip erase");
        end
        // R10 commands during busy are ignored
        do_cmd(8'h06, '0, 8'h00, 1'b1, "R10 wren");
        do_cmd(8'h01, '0, 8'h00, 1'b1, "R10 clear bp");
        do_cmd(8'h06, '0, 8'h00, 1'b1, "R10 wren2");
        cmd_valid = 1'b1; cmd_op = 8'hD8; cmd_addr = 19'h10000;
        @(negedge clk);
        cmd_op = 8'h04;
        @(negedge clk);
        check("R10 start pulse", {31'd0, busy}, 1);
        cmd_op = 8'h01; cmd_data = 8'h9C;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 wrdi ignored", {30'd0, cmd_accept, cmd_reject}, 0);
        @(negedge clk);
        check("R10 wrsr ignored", {30'd0, cmd_accept, cmd_reject}, 0);
        check("R10 wel kept", {24'd0, status}, 32'h03);
        while (busy === 1'b1) @(negedge clk);
        check("R10 end status", {24'd0, status}, 32'h00);
        m_wel = 1'b0; m_bp = 3'b000; m_srp = 1'b0;
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            r = $urandom;
            op = ((r & 3) == 0) ? 8'h06 : ops[($urandom % 7)];
            do_cmd(op, 19'($urandom), 8'($urandom), 1'($urandom), "R4-mix random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule